// File: doc/BRIEF.md
# Usage and Miss-Rate Degree Selector

This block sits beside a cache's demand-access path and decides, for each load, how many following cache lines to prefetch. It keeps a table of recently seen load instruction addresses (PCs). Every PC in the table is graded on two independent scales. The first is usage: how often the PC has been seen lately, held as a saturating counter compared against a programmable threshold, which makes the PC hot or cold. The second is its miss ratio over the last sampling window, which marks it as miss-heavy or miss-light. Together the two grades select a low, standard or high prefetch degree.

Each accepted access produces two things: a one-cycle degree report, and a burst of sequential next-line prefetch addresses issued one per cycle. While a burst is still being issued, the block holds off further accesses by lowering its ready output. Usage counters are halved at every window boundary, so a phase that has gone quiet ages out of the hot class. Miss ratios are recomputed at the same boundary from the counts gathered in that window.

Top module: `pf_degree_sel`

## Requirements
- R1: After reset, `acc_ready` is 1, `deg_valid` and `pf_valid` are 0, and the table holds no PC, so the first access of any PC is a table miss.
- R2: An access is accepted on a rising edge where `acc_valid` and `acc_ready` are both 1. In the following cycle `deg_valid` is 1 for exactly one cycle and `deg_value` carries the chosen degree.
- R3: For a PC found in the table, the degree depends on its grading before the current access is counted. Hot and miss-heavy gives 8. Cold and miss-light gives 1. Any other combination gives 4.
- R4: Each entry has a 4-bit usage counter. The counter rises by one on every accepted access to that PC and saturates at 15. A PC is hot when its counter is greater than or equal to the 4-bit `hot_thresh` input.
- R5: Accepted accesses are counted in windows of 70. On the 70th access of a window, the current access is counted first. Then every entry's usage counter is halved (shifted right by one), and its miss-heavy flag is set to (2 × misses > accesses) for that window. Its window counts then restart at zero. An entry with no accesses in the window becomes miss-light.
- R6: A PC not found in the table is given degree 4. It takes over the least-recently-used entry (never-used entries are taken before any used one). The entry starts with usage 0, miss-light and empty window counts, and the current access is then counted into it.
- R7: With 64-byte lines, the k-th prefetch address is ((acc_addr >> 6) + k) << 6, taken modulo 2^32, for k = 1 up to the degree. `pf_valid` is 1 for exactly that many consecutive cycles, starting in the cycle after acceptance, with one address per cycle.
- R8: `acc_ready` is 0 in every cycle in which `pf_valid` is 1. It returns to 1 in the cycle after the last prefetch address.
- R9: `acc_valid` asserted while `acc_ready` is 0 is ignored. It produces no degree report and no prefetch, does not enter the PC into the table, and does not advance the window count.
- R10: The table holds 128 PCs. Once more distinct PCs than that have been seen, the least recently used PC is evicted, and its next access is again a table miss with degree 4. A recently used PC keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access present |
| acc_pc | input | 32 | PC of the load |
| acc_addr | input | 32 | Byte address of the demand access |
| acc_miss | input | 1 | 1 when the demand access missed |
| hot_thresh | input | 4 | Usage level at or above which a PC is hot |
| acc_ready | output | 1 | Block can accept an access this cycle |
| deg_valid | output | 1 | Degree report for the last accepted access |
| deg_value | output | 4 | Chosen degree (1, 4 or 8) |
| pf_valid | output | 1 | Prefetch address valid |
| pf_addr | output | 32 | Line-aligned prefetch address |

## Verification
The hardest situation to reach from the ports is eviction that overlaps a window boundary. The table first has to be filled past 128 distinct PCs. Only then can a revisit of an aged-out PC be told apart from a revisit of one that is still resident, and by that point the halving of usage counters has already reshaped which PCs are hot. The stimulus runs a phased pattern that builds up a hot, miss-heavy PC, then sweeps 130 fresh PCs whose accesses straddle several 70-access boundaries, and then revisits both the oldest and the newest of them. A reference model of grading, ranks and windows in the bench predicts every degree and address, and a burst is disturbed with `acc_valid` pulses to show that they leave no trace.

// File: rtl/pf_sel_pkg.sv
package pf_sel_pkg;

  localparam int DEG_W = 4;
  localparam int CNT_CALC_W = 16;

  typedef logic [DEG_W-1:0] deg_t;

  typedef struct packed {
    logic hit;
    logic hot;
    logic heavy;
  } grade_t;

  function automatic deg_t pick_degree(input grade_t g, input deg_t lo,
                                       input deg_t std_d, input deg_t hi);
    if (!g.hit)                return std_d;
    if (g.hot && g.heavy)      return hi;
    if (!g.hot && !g.heavy)    return lo;
    return std_d;
  endfunction

  function automatic logic miss_heavy(input logic [CNT_CALC_W-1:0] seen,
                                      input logic [CNT_CALC_W-1:0] missed);
    return {missed[CNT_CALC_W-2:0], 1'b0} > seen;
  endfunction

endpackage

// File: rtl/pf_window_ctr.sv
module pf_window_ctr #(
  parameter int WIN = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic win_end
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt;

  assign win_end = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= win_end ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/pf_usage_table.sv
module pf_usage_table
  import pf_sel_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int PC_W    = 32,
  parameter int UCNT_W  = 4,
  parameter int WIN     = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [PC_W-1:0]   pc,
  input  logic              miss,
  input  logic [UCNT_W-1:0] thr,
  input  logic              win_end,
  output grade_t            grade
);
  localparam int IW = $clog2(ENTRIES);
  localparam int SW = $clog2(WIN + 1);
  localparam logic [UCNT_W-1:0] UMAX = '1;
  localparam logic [IW-1:0] OLDEST = IW'(ENTRIES - 1);

  logic              e_v    [ENTRIES];
  logic [PC_W-1:0]   e_tag  [ENTRIES];
  logic [UCNT_W-1:0] e_u    [ENTRIES];
  logic [SW-1:0]     e_acc  [ENTRIES];
  logic [SW-1:0]     e_mis  [ENTRIES];
  logic              e_hvy  [ENTRIES];
  logic [IW-1:0]     e_rank [ENTRIES];

  logic [ENTRIES-1:0] match;
  logic               hit;
  logic [IW-1:0]      hit_idx, victim, sel;
  logic [IW-1:0]      sel_rank;
  logic [UCNT_W-1:0]  b_u, n_u;
  logic [SW-1:0]      b_acc, b_mis, n_acc, n_mis;
  logic               b_hvy, n_hvy_win;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = e_v[g] && (e_tag[g] == pc);
  end

  always_comb begin
    hit_idx = '0;
    victim  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i])              hit_idx = IW'(i);
      if (e_rank[i] == OLDEST)   victim  = IW'(i);
    end
  end

  assign hit      = |match;
  assign sel      = hit ? hit_idx : victim;
  assign sel_rank = e_rank[sel];

  assign b_u   = hit ? e_u[sel]   : '0;
  assign b_acc = hit ? e_acc[sel] : '0;
  assign b_mis = hit ? e_mis[sel] : '0;
  assign b_hvy = hit ? e_hvy[sel] : 1'b0;

  assign n_u   = (b_u == UMAX) ? b_u : b_u + UCNT_W'(1);
  assign n_acc = b_acc + SW'(1);
  assign n_mis = b_mis + SW'(miss);
  assign n_hvy_win = miss_heavy(CNT_CALC_W'(n_acc), CNT_CALC_W'(n_mis));

  assign grade.hit   = hit;
  assign grade.hot   = hit && (e_u[sel] >= thr);
  assign grade.heavy = hit && e_hvy[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_v[i]    <= 1'b0;
        e_tag[i]  <= '0;
        e_u[i]    <= '0;
        e_acc[i]  <= '0;
        e_mis[i]  <= '0;
        e_hvy[i]  <= 1'b0;
        e_rank[i] <= IW'(i);
      end
    end else if (upd) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IW'(i) == sel) begin
          e_v[i]    <= 1'b1;
          e_tag[i]  <= pc;
          e_rank[i] <= '0;
          if (win_end) begin
            e_u[i]   <= n_u >> 1;
            e_acc[i] <= '0;
            e_mis[i] <= '0;
            e_hvy[i] <= n_hvy_win;
          end else begin
            e_u[i]   <= n_u;
            e_acc[i] <= n_acc;
            e_mis[i] <= n_mis;
            e_hvy[i] <= b_hvy;
          end
        end else begin
          if (e_rank[i] < sel_rank) e_rank[i] <= e_rank[i] + IW'(1);
          if (win_end) begin
            e_u[i]   <= e_u[i] >> 1;
            e_acc[i] <= '0;
            e_mis[i] <= '0;
            e_hvy[i] <= miss_heavy(CNT_CALC_W'(e_acc[i]), CNT_CALC_W'(e_mis[i]));
          end
        end
      end
    end
  end
endmodule

// File: rtl/pf_burst.sv
module pf_burst
  import pf_sel_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  deg_t              deg_in,
  input  logic [ADDR_W-1:0] addr,
  output logic              deg_valid,
  output deg_t              deg_out,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              idle
);
  localparam int LW = ADDR_W - LINE_OFF;

  deg_t          rem;
  logic [LW-1:0] cur_line;

  assign pf_valid = (rem != '0);
  assign idle     = (rem == '0);
  assign pf_addr  = {cur_line, {LINE_OFF{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem       <= '0;
      cur_line  <= '0;
      deg_valid <= 1'b0;
      deg_out   <= '0;
    end else if (start) begin
      rem       <= deg_in;
      cur_line  <= addr[ADDR_W-1:LINE_OFF] + LW'(1);
      deg_valid <= 1'b1;
      deg_out   <= deg_in;
    end else begin
      deg_valid <= 1'b0;
      if (rem != '0) begin
        rem      <= rem - DEG_W'(1);
        cur_line <= cur_line + LW'(1);
      end
    end
  end
endmodule

// File: rtl/pf_degree_sel.sv
module pf_degree_sel
  import pf_sel_pkg::*;
#(
  parameter int ENTRIES  = 128,
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int UCNT_W   = 4,
  parameter int WIN      = 70,
  parameter int DEG_LO   = 1,
  parameter int DEG_STD  = 4,
  parameter int DEG_HI   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_miss,
  input  logic [UCNT_W-1:0] hot_thresh,
  output logic              acc_ready,
  output logic              deg_valid,
  output logic [DEG_W-1:0]  deg_value,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam deg_t D_LO  = DEG_W'(DEG_LO);
  localparam deg_t D_STD = DEG_W'(DEG_STD);
  localparam deg_t D_HI  = DEG_W'(DEG_HI);

  logic   acc_fire;
  logic   win_end;
  logic   burst_idle;
  grade_t grade;
  deg_t   chosen;

  assign acc_ready = burst_idle;
  assign acc_fire  = acc_valid && acc_ready;
  assign chosen    = pick_degree(grade, D_LO, D_STD, D_HI);

  pf_window_ctr #(.WIN(WIN)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (acc_fire),
    .win_end (win_end)
  );

  pf_usage_table #(
    .ENTRIES (ENTRIES),
    .PC_W    (PC_W),
    .UCNT_W  (UCNT_W),
    .WIN     (WIN)
  ) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (acc_fire),
    .pc      (acc_pc),
    .miss    (acc_miss),
    .thr     (hot_thresh),
    .win_end (win_end),
    .grade   (grade)
  );

  pf_burst #(
    .ADDR_W   (ADDR_W),
    .LINE_OFF (LINE_OFF)
  ) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (acc_fire),
    .deg_in    (chosen),
    .addr      (acc_addr),
    .deg_valid (deg_valid),
    .deg_out   (deg_value),
    .pf_valid  (pf_valid),
    .pf_addr   (pf_addr),
    .idle      (burst_idle)
  );
endmodule

// File: rtl/pf_degree_sel_chk.sv
module pf_degree_sel_chk #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int WIN      = 70,
  parameter int DEG_LO   = 1,
  parameter int DEG_STD  = 4,
  parameter int DEG_HI   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_ready,
  input logic              deg_valid,
  input logic [3:0]        deg_value,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              acc_fire,
  input logic              win_end
);
  localparam int CW = $clog2(WIN);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << LINE_OFF;
  localparam int LW = ADDR_W - LINE_OFF;

  logic [CW-1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n)        seen <= '0;
    else if (acc_fire) seen <= (seen == CW'(WIN - 1)) ? '0 : seen + CW'(1);
  end

  AST_DEG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    deg_valid |-> (deg_value == 4'(DEG_LO) || deg_value == 4'(DEG_STD) || deg_value == 4'(DEG_HI))); // R3
  AST_DEG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    deg_valid |=> !deg_valid); // R2
  AST_DEG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    deg_valid |-> $past(acc_valid && acc_ready)); // R9
  AST_PF_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !acc_ready); // R8
  AST_PF_FIRST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    deg_valid |-> (pf_valid && pf_addr == {$past(acc_addr[ADDR_W-1:LINE_OFF]) + LW'(1), {LINE_OFF{1'b0}}})); // R7
  AST_PF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && $past(pf_valid)) |-> (pf_addr == $past(pf_addr) + STEP)); // R7
  AST_WIN_AT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> (win_end == (seen == CW'(WIN - 1)))); // R5
  AST_WIN_NEEDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> acc_fire); // R5
endmodule

bind pf_degree_sel pf_degree_sel_chk #(
  .ADDR_W   (ADDR_W),
  .LINE_OFF (LINE_OFF),
  .WIN      (WIN),
  .DEG_LO   (DEG_LO),
  .DEG_STD  (DEG_STD),
  .DEG_HI   (DEG_HI)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .acc_ready (acc_ready),
  .deg_valid (deg_valid),
  .deg_value (deg_value),
  .pf_valid  (pf_valid),
  .pf_addr   (pf_addr),
  .acc_fire  (acc_fire),
  .win_end   (win_end)
);

// File: tb/pf_degree_sel_bench.sv
module pf_degree_sel_bench;
  localparam int CLK_P = 10;
  localparam int N = 128;
  localparam int WINDOW = 70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_pc = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_miss = 1'b0;
  logic [3:0]  hot_thresh = 4'd3;
  logic        acc_ready, deg_valid, pf_valid;
  logic [3:0]  deg_value;
  logic [31:0] pf_addr;

  always #(CLK_P/2) clk = ~clk;

  pf_degree_sel u_pf_degree_sel (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc),
    .acc_addr(acc_addr), .acc_miss(acc_miss), .hot_thresh(hot_thresh),
    .acc_ready(acc_ready), .deg_valid(deg_valid), .deg_value(deg_value),
    .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  typedef struct {
    bit          is_deg;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  string g_tag = "";

  bit          m_v    [N];
  logic [31:0] m_tag  [N];
  int          m_u    [N];
  int          m_acc  [N];
  int          m_mis  [N];
  bit          m_hvy  [N];
  int          m_rank [N];
  int          m_seen = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_u[i] = 0; m_acc[i] = 0;
      m_mis[i] = 0; m_hvy[i] = 0; m_rank[i] = i;
    end
    m_seen = 0;
  endtask

  task automatic model_step(input logic [31:0] pc, input bit miss, output int deg, output bit hit);
    int idx, r;
    bit hot;
    hit = 0; idx = 0;
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == pc) begin hit = 1; idx = i; end
    if (hit) begin
      hot = (m_u[idx] >= int'(hot_thresh));
      if (hot && m_hvy[idx])        deg = 8;
      else if (!hot && !m_hvy[idx]) deg = 1;
      else                          deg = 4;
    end else begin
      for (int i = 0; i < N; i++) if (m_rank[i] == N - 1) idx = i;
      deg = 4;
      m_v[idx] = 1; m_tag[idx] = pc; m_u[idx] = 0;
      m_acc[idx] = 0; m_mis[idx] = 0; m_hvy[idx] = 0;
    end
    if (m_u[idx] < 15) m_u[idx]++;
    m_acc[idx]++;
    if (miss) m_mis[idx]++;
    r = m_rank[idx];
    for (int i = 0; i < N; i++) if (m_rank[i] < r) m_rank[i]++;
    m_rank[idx] = 0;
    m_seen++;
    if (m_seen == WINDOW) begin
      m_seen = 0;
      for (int i = 0; i < N; i++) begin
        m_hvy[i] = (2 * m_mis[i] > m_acc[i]);
        m_u[i] = m_u[i] / 2;
        m_acc[i] = 0; m_mis[i] = 0;
      end
    end
  endtask

  task automatic send(input logic [31:0] pc, input logic [31:0] addr, input bit miss);
    int d;
    bit hit;
    string t;
    logic [31:0] ln;
    while (!acc_ready) @(negedge clk);
    acc_valid = 1; acc_pc = pc; acc_addr = addr; acc_miss = miss;
    model_step(pc, miss, d, hit);
    t = (g_tag != "") ? g_tag : (hit ? "R3/R4/R5 degree" : "R6 table miss degree");
    q.push_back('{is_deg: 1'b1, val: 32'(d), tag: t});
    ln = addr >> 6;
    for (int k = 1; k <= d; k++)
      q.push_back('{is_deg: 1'b0, val: (ln + 32'(k)) << 6, tag: "R7 prefetch address"});
    @(negedge clk);
    acc_valid = 0;
  endtask

  // monitor: compares outputs with the expected queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (deg_valid) begin
        if (q.size() == 0 || !q[0].is_deg) begin
          chk(0, "R9 unexpected degree report", 32'(deg_value), 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(32'(deg_value) == e.val, {"R2 ", e.tag}, 32'(deg_value), e.val);
        end
      end
      if (pf_valid) begin
        chk(!acc_ready, "R8 ready low during burst", 32'(acc_ready), 32'h0);
        if (q.size() == 0 || q[0].is_deg) begin
          chk(0, "R7 unexpected prefetch", pf_addr, 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(pf_addr == e.val, e.tag, pf_addr, e.val);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog expired", 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lcg;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(acc_ready == 1'b1, "R1 ready after reset", 32'(acc_ready), 32'h1);
    chk(deg_valid == 1'b0, "R1 no degree after reset", 32'(deg_valid), 32'h0);
    chk(pf_valid == 1'b0, "R1 no prefetch after reset", 32'(pf_valid), 32'h0);

    // phase A: miss-heavy hot PC, quiet PC, rare PC over three windows
    hot_thresh = 4'd3;
    g_tag = "R1 first access degree";
    send(32'h0000_4000, 32'h1000_0000, 1'b1);
    g_tag = "";
    for (int i = 1; i < 210; i++) begin
      case (i % 7)
        0, 1, 2: send(32'h0000_4000, 32'h1000_0000 + 32'(i * 64), 1'b1);
        3, 4:    send(32'h0000_4010, 32'h2000_0000 + 32'(i * 8), 1'b0);
        5:       send(32'h0000_4020, 32'h3000_0000 + 32'(i * 256), i[3]);
        default: send((i % 35 == 6) ? 32'h0000_4030 : 32'h0000_4040, 32'h4000_0000 + 32'(i), 1'b0);
      endcase
    end

    // phase B: threshold extremes (R4)
    hot_thresh = 4'd15;
    for (int i = 0; i < 60; i++) send(32'h0000_4000 + 32'((i % 3) * 16), 32'h5000_0040 + 32'(i * 64), i[0]);
    hot_thresh = 4'd0;
    for (int i = 0; i < 60; i++) send(32'h0000_4000 + 32'((i % 4) * 16), 32'h5100_0000 + 32'(i * 64), i[1]);

    // phase C: sweep past table capacity, then revisit oldest and newest (R10)
    hot_thresh = 4'd3;
    for (int i = 0; i < 130; i++) send(32'h0001_0000 + 32'(i * 4), 32'h6000_0000 + 32'(i * 128), i[0]);
    g_tag = "R10 evicted or resident revisit";
    send(32'h0001_0000, 32'h6100_0000, 1'b0);
    send(32'h0001_0000 + 32'(129 * 4), 32'h6100_1000, 1'b1);
    send(32'h0000_4000, 32'h6100_2000, 1'b1);
    g_tag = "";

    // phase D: valid pulses while busy are ignored (R9)
    send(32'h0002_0000, 32'h7000_0000, 1'b0);
    acc_valid = 1; acc_pc = 32'hDEAD_0000; acc_addr = 32'h7777_0000; acc_miss = 1'b1;
    @(negedge clk);
    @(negedge clk);
    acc_valid = 0;
    g_tag = "R9 ignored PC still absent";
    send(32'hDEAD_0000, 32'h7100_0000, 1'b1);
    g_tag = "";

    // phase E: pseudo-random mix with address wrap
    hot_thresh = 4'd2;
    lcg = 32'h1234_5678;
    for (int i = 0; i < 200; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      send(32'h0003_0000 + 32'(lcg[27:24]) * 32'h10,
           (i % 50 == 0) ? 32'hFFFF_FF80 : {lcg[31:8], 8'h00}, lcg[13]);
    end

    while (!acc_ready || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R7 all expected outputs seen", 32'(q.size()), 32'h0);
    done = 1;
    finish_run();
  end
endmodule